// File: doc/BRIEF.md
# Reset Release Sequencer with Oscillator and PLL Settling

This block keeps a processor core in reset after a power event until the supply, the crystal oscillator and, when selected, the PLL have had time to settle. A power-on or brown-out event first starts a short power-on delay. An optional long power-up delay follows, then an oscillator start-up count. In PLL mode a short extra lock delay comes after that, and only then is the core released. The long and short delays count pulses of a free-running reference tick. The oscillator count uses pulses that mark oscillator clock edges. Each count is a parameter, so a bench can shrink milliseconds to a few ticks.

Once the core is running, the block produces the four-phase instruction-cycle sequence and gates the core clock. It also handles sleep. A sleep request is accepted only at the last phase of an instruction cycle, so the core stops at the start of the next cycle with the oscillator off. An interrupt, an external reset or a watchdog reset wakes the block. After a wake it repeats the oscillator count and, in PLL mode, the lock delay. It does not repeat the power-up delay. A phase-status code makes the current stage visible.

Top module: `rrs_seq`

## Requirements
- R1: While `rst_n` is low, and after it rises, the block shows phase code 0 (power-on delay) with `core_rst_o`=1, `core_clk_en_o`=0, `osc_en_o`=1 and `qphase_o`=0. Phase codes are: 0 power-on delay, 1 power-up delay, 2 oscillator start-up, 3 PLL lock, 4 running, 5 sleep.
- R2: A high `por_i` or `bor_i` at a clock edge, in any phase, gives phase 0 in the next cycle and restarts the whole sequence with a cleared count.
- R3: Phase 0 lasts exactly `POR_TICKS` tick pulses. It then moves to phase 1 if `pwrt_en_i`=1, and to phase 2 otherwise.
- R4: Phase 1 lasts exactly `PWRT_TICKS` tick pulses and is entered only from phase 0 with `pwrt_en_i`=1. When `pwrt_en_i`=0 it is never visited.
- R5: Phase 2 lasts exactly `OST_EDGES` pulses of `osc_edge_i`. Tick pulses have no effect on it.
- R6: After phase 2, with `pll_mode_i`=1, phase 3 lasts exactly `PLL_TICKS` tick pulses before phase 4. With `pll_mode_i`=0, phase 2 goes straight to phase 4.
- R7: After a power event, `core_rst_o` stays 1 in phases 0 to 3. It is 0 in phase 4 unless an external or watchdog reset is present.
- R8: `ext_rst_i` or `wdt_rst_i` drives `core_rst_o` to 1 in the same cycle. Outside sleep neither input changes the phase or the delay counts.
- R9: In phase 4, `core_clk_en_o`=1 and `qphase_o` advances by one (mod 4) every cycle. Outside phase 4, `core_clk_en_o`=0.
- R10: A held `sleep_req_i` enters phase 5 only from a cycle with `qphase_o`=3. In phase 5, `qphase_o`=0, `osc_en_o`=0, `core_clk_en_o`=0 and `core_rst_o`=0. The block stays there until a wake event.
- R11: In phase 5, `irq_i`, `ext_rst_i` or `wdt_rst_i` moves the block to phase 2, then to phase 3 if in PLL mode, then to phase 4, without visiting phase 0 or 1. After an interrupt wake, `core_rst_o` stays 0. After a reset wake it stays 1 until phase 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Reference tick pulse for the power-on, power-up and lock delays |
| osc_edge_i | input | 1 | One pulse per oscillator clock edge |
| por_i | input | 1 | Power-on event |
| bor_i | input | 1 | Brown-out event |
| ext_rst_i | input | 1 | External reset request |
| wdt_rst_i | input | 1 | Watchdog reset request |
| irq_i | input | 1 | Interrupt wake request |
| pwrt_en_i | input | 1 | Enables the long power-up delay |
| pll_mode_i | input | 1 | Selects PLL mode (adds lock delay) |
| sleep_req_i | input | 1 | Sleep request, held until accepted |
| core_rst_o | output | 1 | Reset to the core |
| core_clk_en_o | output | 1 | Core clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| qphase_o | output | 2 | Instruction-cycle phase, 0 to 3 |
| phase_o | output | 3 | Sequencer phase code |

## Verification
Suppose the shared count is not cleared on a power event, or a stage is skipped. The next release of the core would then come early or late by a whole number of tick or edge pulses, so the bench counts pulses per phase rather than cycles. A wrong wake path shows within one cycle of the wake event, either as phase 0 or 1 reappearing or as `core_rst_o` rising after an interrupt wake. A misaligned sleep entry shows on the cycle the sleep code appears, through the last instruction phase seen before it.

// File: rtl/rrs_pkg.sv
// Shared phase encoding for the reset release sequencer.
package rrs_pkg;
    typedef enum logic [2:0] {
        PH_POR   = 3'd0,
        PH_PWRT  = 3'd1,
        PH_OST   = 3'd2,
        PH_PLL   = 3'd3,
        PH_RUN   = 3'd4,
        PH_SLEEP = 3'd5
    } phase_e;
endpackage

// File: rtl/rrs_delay_cnt.sv
// Shared delay counter. It counts step pulses and flags the pulse that
// completes limit_i steps, then restarts from zero by itself.
// Assumes limit_i >= 1 and that limit_i changes only together with a wrap.
module rrs_delay_cnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         step_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o
);
    logic [W-1:0] cnt_q;

    // Terminal step: this pulse completes the programmed count.
    always_comb hit_o = step_i && (cnt_q == (limit_i - W'(1)));

    // Count register: clears on request or on completion, otherwise counts steps.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (hit_o) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/rrs_qphase.sv
// Four-phase instruction-cycle generator. It advances while run_i is high
// and is held at the first phase otherwise.
module rrs_qphase #(
    parameter int unsigned NPH = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run_i,
    output logic [$clog2(NPH)-1:0] q_o,
    output logic                   last_o
);
    localparam int unsigned QW = $clog2(NPH);
    logic [QW-1:0] q_q;

    // Phase register: wraps after the last phase, held at phase zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            q_q <= '0;
        end else if (q_q == QW'(NPH - 1)) begin
            q_q <= '0;
        end else begin
            q_q <= q_q + QW'(1);
        end
    end

    // Output and last-phase flag.
    always_comb begin
        q_o    = q_q;
        last_o = (q_q == QW'(NPH - 1));
    end
endmodule

// File: rtl/rrs_seq.sv
// Reset release sequencer top. A power event is followed by the power-on
// delay, the optional power-up delay, the oscillator start-up count and,
// in PLL mode, a lock delay. The core is released after that.
// Also runs the instruction phases, sleep entry and wake.
// Assumes pwrt_en_i and pll_mode_i are static while a delay runs.
module rrs_seq #(
    parameter int unsigned POR_TICKS  = 16,
    parameter int unsigned PWRT_TICKS = 72000,
    parameter int unsigned OST_EDGES  = 1024,
    parameter int unsigned PLL_TICKS  = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       osc_edge_i,
    input  logic       por_i,
    input  logic       bor_i,
    input  logic       ext_rst_i,
    input  logic       wdt_rst_i,
    input  logic       irq_i,
    input  logic       pwrt_en_i,
    input  logic       pll_mode_i,
    input  logic       sleep_req_i,
    output logic       core_rst_o,
    output logic       core_clk_en_o,
    output logic       osc_en_o,
    output logic [1:0] qphase_o,
    output logic [2:0] phase_o
);
    import rrs_pkg::*;

    localparam int unsigned M1      = (POR_TICKS > PWRT_TICKS) ? POR_TICKS : PWRT_TICKS;
    localparam int unsigned M2      = (OST_EDGES > PLL_TICKS) ? OST_EDGES : PLL_TICKS;
    localparam int unsigned CNT_MAX = (M1 > M2) ? M1 : M2;
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] LIM_POR  = CW'(POR_TICKS);
    localparam logic [CW-1:0] LIM_PWRT = CW'(PWRT_TICKS);
    localparam logic [CW-1:0] LIM_OST  = CW'(OST_EDGES);
    localparam logic [CW-1:0] LIM_PLL  = CW'(PLL_TICKS);

    phase_e        ph_q, ph_d;
    logic          warm_q, warm_d;
    logic          power_evt, rst_req;
    logic          step, hit;
    logic [CW-1:0] lim;
    logic          q_last;

    always_comb power_evt = por_i || bor_i;
    always_comb rst_req   = ext_rst_i || wdt_rst_i;

    // Step source and length of the current delay phase.
    always_comb begin
        step = 1'b0;
        lim  = LIM_POR;
        unique case (ph_q)
            PH_POR:  begin step = tick_i;     lim = LIM_POR;  end
            PH_PWRT: begin step = tick_i;     lim = LIM_PWRT; end
            PH_OST:  begin step = osc_edge_i; lim = LIM_OST;  end
            PH_PLL:  begin step = tick_i;     lim = LIM_PLL;  end
            default: begin step = 1'b0;       lim = LIM_POR;  end
        endcase
    end

    rrs_delay_cnt #(.W(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (power_evt),
        .step_i  (step),
        .limit_i (lim),
        .hit_o   (hit)
    );

    rrs_qphase #(.NPH(4)) u_q (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (ph_q == PH_RUN),
        .q_o    (qphase_o),
        .last_o (q_last)
    );

    // Next phase: a power event wins, then delay completion, sleep and wake.
    always_comb begin
        ph_d   = ph_q;
        warm_d = warm_q;
        if (power_evt) begin
            ph_d   = PH_POR;
            warm_d = 1'b0;
        end else begin
            unique case (ph_q)
                PH_POR:   if (hit) ph_d = pwrt_en_i ? PH_PWRT : PH_OST;
                PH_PWRT:  if (hit) ph_d = PH_OST;
                PH_OST:   if (hit) ph_d = pll_mode_i ? PH_PLL : PH_RUN;
                PH_PLL:   if (hit) ph_d = PH_RUN;
                PH_RUN: begin
                    warm_d = 1'b0;
                    if (sleep_req_i && q_last) ph_d = PH_SLEEP;
                end
                PH_SLEEP: begin
                    if (rst_req) begin
                        ph_d   = PH_OST;
                        warm_d = 1'b0;
                    end else if (irq_i) begin
                        ph_d   = PH_OST;
                        warm_d = 1'b1;
                    end
                end
                default:  ph_d = PH_POR;
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_POR;
            warm_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            warm_q <= warm_d;
        end
    end

    // Outputs: reset hold, clock gating and oscillator control.
    always_comb begin
        core_rst_o    = rst_req
                     || (ph_q == PH_POR) || (ph_q == PH_PWRT)
                     || (((ph_q == PH_OST) || (ph_q == PH_PLL)) && !warm_q);
        core_clk_en_o = (ph_q == PH_RUN);
        osc_en_o      = (ph_q != PH_SLEEP);
        phase_o       = ph_q;
    end
endmodule

// File: rtl/rrs_seq_chk.sv
// Property checker for rrs_seq, attached through bind below.
module rrs_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       por_i,
    input logic       bor_i,
    input logic       ext_rst_i,
    input logic       wdt_rst_i,
    input logic       pwrt_en_i,
    input logic       pll_mode_i,
    input logic       core_rst_o,
    input logic       core_clk_en_o,
    input logic       osc_en_o,
    input logic [1:0] qphase_o,
    input logic [2:0] phase_o
);
    localparam logic [2:0] C_POR = 3'd0, C_PWRT = 3'd1, C_OST = 3'd2,
                           C_PLL = 3'd3, C_RUN = 3'd4, C_SLP = 3'd5;

    assert_power_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (por_i || bor_i) |=> (phase_o == C_POR));

    assert_pwrt_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == C_PWRT && $past(phase_o) != C_PWRT)
        |-> ($past(phase_o) == C_POR && $past(pwrt_en_i)));

    assert_pll_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == C_PLL && $past(phase_o) != C_PLL)
        |-> ($past(phase_o) == C_OST && $past(pll_mode_i)));

    assert_hold_rst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == C_POR || phase_o == C_PWRT) |-> core_rst_o);

    assert_ext_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rst_i || wdt_rst_i) |-> core_rst_o);

    assert_qstep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == C_RUN && $past(phase_o) == C_RUN)
        |-> (qphase_o == $past(qphase_o) + 2'd1));

    assert_sleep_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == C_SLP && $past(phase_o) == C_RUN) |-> ($past(qphase_o) == 2'd3));

    assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == C_SLP) |-> (qphase_o == 2'd0 && !osc_en_o && !core_clk_en_o));

    assert_wake_path_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase_o) == C_SLP && phase_o != C_SLP)
        |-> (phase_o == C_OST || phase_o == C_POR));
endmodule

bind rrs_seq rrs_seq_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .por_i         (por_i),
    .bor_i         (bor_i),
    .ext_rst_i     (ext_rst_i),
    .wdt_rst_i     (wdt_rst_i),
    .pwrt_en_i     (pwrt_en_i),
    .pll_mode_i    (pll_mode_i),
    .core_rst_o    (core_rst_o),
    .core_clk_en_o (core_clk_en_o),
    .osc_en_o      (osc_en_o),
    .qphase_o      (qphase_o),
    .phase_o       (phase_o)
);

// File: tb/rrs_seq_tb_top.sv
`timescale 1ns/1ps
module rrs_seq_tb_top;
    localparam int P_POR = 3, P_PWRT = 5, P_OST = 4, P_PLL = 2;
    localparam logic [2:0] C_POR = 3'd0, C_PWRT = 3'd1, C_OST = 3'd2,
                           C_PLL = 3'd3, C_RUN = 3'd4, C_SLP = 3'd5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tick_i = 1'b0, osc_edge_i = 1'b0, por_i = 1'b0, bor_i = 1'b0;
    logic irq_i = 1'b0, pwrt_en_i = 1'b1, pll_mode_i = 1'b0, sleep_req_i = 1'b0;
    logic ext_req = 1'b0, wdt_req = 1'b0, inj_ext = 1'b0, inj_wdt = 1'b0;
    logic ext_rst_i, wdt_rst_i;
    logic core_rst_o, core_clk_en_o, osc_en_o;
    logic [1:0] qphase_o;
    logic [2:0] phase_o;

    assign ext_rst_i = ext_req | inj_ext;
    assign wdt_rst_i = wdt_req | inj_wdt;

    always #10 clk = ~clk;   // 50 MHz

    rrs_seq #(.POR_TICKS(P_POR), .PWRT_TICKS(P_PWRT), .OST_EDGES(P_OST), .PLL_TICKS(P_PLL)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .osc_edge_i(osc_edge_i),
        .por_i(por_i), .bor_i(bor_i), .ext_rst_i(ext_rst_i), .wdt_rst_i(wdt_rst_i),
        .irq_i(irq_i), .pwrt_en_i(pwrt_en_i), .pll_mode_i(pll_mode_i),
        .sleep_req_i(sleep_req_i), .core_rst_o(core_rst_o), .core_clk_en_o(core_clk_en_o),
        .osc_en_o(osc_en_o), .qphase_o(qphase_o), .phase_o(phase_o));

    int n_chk = 0, n_bad = 0;
    int cyc = 0, tdiv = 1, odiv = 1;
    bit inject = 0, expect_rst = 1, log_clr = 0, done = 0;
    int tk[8], eg[8], vis[8];
    int bad = 0, align_bad = 0;
    logic [2:0] prev_ph = 3'd0;
    logic [1:0] prev_q = 2'd0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Stimulus pulses, changed away from the active edge.
    always @(negedge clk) begin
        tick_i     <= (cyc % tdiv) == 0;
        osc_edge_i <= (cyc % odiv) == 0;
        inj_ext    <= inject && phase_o != C_RUN && (cyc % 7) == 3;
        inj_wdt    <= inject && phase_o != C_RUN && (cyc % 7) == 5;
    end

    // Per-phase pulse counts and per-cycle output expectations.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        prev_ph <= phase_o;
        prev_q  <= qphase_o;
        if (log_clr) begin
            for (int p = 0; p < 8; p++) begin tk[p] = 0; eg[p] = 0; vis[p] = 0; end
            bad = 0;
        end else if (rst_n && !por_i && !bor_i) begin
            vis[phase_o] = 1;
            if (tick_i) tk[phase_o] = tk[phase_o] + 1;
            if (osc_edge_i) eg[phase_o] = eg[phase_o] + 1;
            case (phase_o)
                C_POR, C_PWRT: if (!core_rst_o || core_clk_en_o) bad++;
                C_OST, C_PLL:  if (core_rst_o != (expect_rst | ext_rst_i | wdt_rst_i) || core_clk_en_o) bad++;
                C_RUN:         if (core_rst_o != (ext_rst_i | wdt_rst_i) || !core_clk_en_o || !osc_en_o) bad++;
                C_SLP:         if (core_rst_o || core_clk_en_o || osc_en_o || qphase_o != 2'd0) bad++;
                default:       bad++;
            endcase
            if (phase_o == C_SLP && prev_ph == C_RUN && prev_q != 2'd3) align_bad++;
        end
    end

    task automatic wait_phase(input logic [2:0] p, input string req);
        int i;
        for (i = 0; i < 600 && phase_o != p; i++) @(negedge clk);
        chk(req, phase_o, p);
    endtask

    task automatic cold_run(input bit use_bor, input bit en, input bit pll,
                            input int td, input int od, input bit inj);
        @(negedge clk);
        pwrt_en_i = en; pll_mode_i = pll; tdiv = td; odiv = od;
        expect_rst = 1; log_clr = 1;
        if (use_bor) bor_i = 1; else por_i = 1;
        @(negedge clk);
        por_i = 0; bor_i = 0; log_clr = 0; inject = inj;
        chk("R2 restart phase", phase_o, C_POR);
        wait_phase(C_RUN, "R7 reaches run");
        inject = 0;
        chk("R3 power-on ticks", tk[C_POR], P_POR);
        chk("R4 power-up ticks", tk[C_PWRT], en ? P_PWRT : 0);
        chk("R4 power-up visited", vis[C_PWRT], en);
        chk("R5 osc edges", eg[C_OST], P_OST);
        chk("R6 lock ticks", tk[C_PLL], pll ? P_PLL : 0);
        chk(inj ? "R8 outputs with resets" : "R7 reset hold", bad, 0);
    endtask

    task automatic sleep_cycle(input int k, input int cause, input bit pll);
        logic [1:0] last_q;
        int i;
        @(negedge clk);
        pll_mode_i = pll;
        repeat (k) @(negedge clk);
        sleep_req_i = 1;
        last_q = qphase_o;
        for (i = 0; i < 10 && phase_o != C_SLP; i++) begin
            last_q = qphase_o;
            @(negedge clk);
        end
        sleep_req_i = 0;
        chk("R10 sleep entered", phase_o, C_SLP);
        chk("R10 last instruction phase", last_q, 3);
        repeat (3) @(negedge clk);
        chk("R10 stays asleep", phase_o, C_SLP);
        chk("R10 sleep outputs", {core_rst_o, core_clk_en_o, osc_en_o, qphase_o}, 0);
        chk("R10 entry alignment", align_bad, 0);
        expect_rst = (cause != 0); log_clr = 1;
        if (cause == 0) irq_i = 1; else if (cause == 1) ext_req = 1; else wdt_req = 1;
        @(negedge clk);
        irq_i = 0; ext_req = 0; wdt_req = 0; log_clr = 0;
        chk("R11 wake to osc start", phase_o, C_OST);
        wait_phase(C_RUN, "R11 back to run");
        chk("R11 no power-on phases", vis[C_POR] + vis[C_PWRT], 0);
        chk("R11 osc edges", eg[C_OST], P_OST);
        chk("R11 lock ticks", tk[C_PLL], pll ? P_PLL : 0);
        chk("R11 reset level on wake", bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 phase", phase_o, C_POR);
        chk("R1 core reset", core_rst_o, 1);
        chk("R1 clock enable", core_clk_en_o, 0);
        chk("R1 osc enable", osc_en_o, 1);
        chk("R1 qphase", qphase_o, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after release", {phase_o, core_rst_o}, {C_POR, 1'b1});

        // Sweep: event kind x power-up enable x PLL mode x tick/edge rates.
        for (int b = 0; b < 2; b++)
            for (int e = 0; e < 2; e++)
                for (int l = 0; l < 2; l++)
                    for (int td = 1; td <= 2; td++)
                        for (int od = 1; od <= 3; od += 2)
                            cold_run(b[0], e[0], l[0], td, od, 1'b0);

        // Restart in the middle of the power-up delay.
        @(negedge clk);
        pwrt_en_i = 1; pll_mode_i = 1; tdiv = 1; por_i = 1;
        @(negedge clk); por_i = 0;
        wait_phase(C_PWRT, "R2 in power-up");
        repeat (2) @(negedge clk);
        log_clr = 1; bor_i = 1;
        @(negedge clk); bor_i = 0; log_clr = 0;
        chk("R2 back to power-on", phase_o, C_POR);
        wait_phase(C_RUN, "R2 run after restart");
        chk("R2 full power-on ticks", tk[C_POR], P_POR);
        chk("R2 full power-up ticks", tk[C_PWRT], P_PWRT);

        // Resets during delays do not alter counts.
        for (int l = 0; l < 2; l++) cold_run(1'b0, 1'b1, l[0], 2, 3, 1'b1);

        // Resets in run mode.
        @(negedge clk); ext_req = 1; #1;
        chk("R8 ext reset immediate", core_rst_o, 1);
        @(negedge clk); ext_req = 0;
        chk("R8 ext keeps run", phase_o, C_RUN);
        wdt_req = 1; #1;
        chk("R8 wdt reset immediate", core_rst_o, 1);
        @(negedge clk); wdt_req = 0; #1;
        chk("R8 wdt keeps run", {phase_o, core_rst_o}, {C_RUN, 1'b0});

        // Instruction phase sweep.
        begin
            logic [1:0] q0;
            q0 = qphase_o;
            for (int i = 1; i <= 8; i++) begin
                @(negedge clk);
                chk("R9 qphase step", qphase_o, (q0 + i) % 4);
                chk("R9 clock enable", core_clk_en_o, 1);
            end
        end

        // Sleep entry at each alignment and every wake cause.
        for (int k = 0; k < 4; k++)
            for (int c = 0; c < 3; c++)
                sleep_cycle(k, c, k[0]);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule